// File: doc/BRIEF.md
# Filtered Falling-Edge Binary Divider with Oscillator Gate

This block is a binary divider and timer that runs on a fast system clock. It takes an asynchronous pulse line, which is usually the output of an external RC or crystal oscillator. The line passes through a synchroniser and a stability filter, and the block counts each high-to-low transition of the filtered level. A chain of `STAGES` binary stages holds the count. A fixed subset of those stages is driven out as divided-down taps: the three lowest stages and stage eleven stay internal.

An active-high reset clears every stage and overrides any count pending in the same cycle. While it is held it also pulls an oscillator-enable output low, so the external oscillator stops. Reset takes effect at once and is released in step with the system clock.

When the count rolls over from all ones to zero, the block raises a single-cycle wrap pulse. A designer can use it as a terminal-count event for timers.

Top module: `ripple_div_top`

## Requirements
- R1: Each filtered high-to-low transition of `pulse_in` advances the internal count by exactly one, in plain binary order.
- R2: A low-to-high transition of `pulse_in` never changes the count.
- R3: While `rst_in` is high, every stage is zero. Reset takes priority over a transition that arrives in the same cycle, and the count stays zero until reset is released.
- R4: `osc_en` is 0 whenever `rst_in` is high, and it returns to 1 no more than three clock cycles after `rst_in` falls.
- R5: A change of `pulse_in` that lasts fewer than `FILT_LEN` clock cycles is ignored. It produces no count and hides no genuine transition around it.
- R6: Tap mapping, with stages numbered from 1 = LSB. `tap_q[i]` is stage `i+4` for `i` from 0 to 6, and `tap_q[7+j]` is stage `12+j`.
- R7: On the transition that follows the all-ones count, the count wraps to zero, and `wrap_pulse` is 1 for exactly one cycle while the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Active-high reset; asserts asynchronously and releases synchronously |
| pulse_in | input | 1 | Asynchronous pulse line to be counted on falling transitions |
| tap_q | output | STAGES-4 | Exposed stage outputs (stages 4-10, then 12 up to STAGES) |
| osc_en | output | 1 | Oscillator enable, low while reset is held |
| wrap_pulse | output | 1 | One-cycle pulse on a wrap from all ones to zero |

## Verification
The bench builds the block with `STAGES=12` and `FILT_LEN=3`. With twelve stages a full wrap takes 4096 transitions, so the bench drives the all-ones state, the rollover and the single-cycle wrap pulse directly, and it still exercises the stage that sits above the hidden stage eleven. A filter length of three lets the bench use one-cycle and two-cycle glitches to show rejection, and to show that levels held four cycles or longer are counted.

// File: rtl/div_pkg.sv
package div_pkg;
   // Stage index (0-based) feeding tap position t, skipping the low hidden
   // stages and the single hidden middle stage.
   function automatic int tap_source(input int t, input int low_hidden, input int mid_hidden);
      int s;
      s = t + low_hidden;
      if (s >= mid_hidden - 1) s = s + 1;
      return s;
   endfunction
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_in,
   output logic rst_int
);
   logic [DEPTH-1:0] chain;

   if (DEPTH < 2) begin : g_bad_depth
      $error("div_rst_sync: DEPTH must be at least 2");
   end

   always_ff @(posedge clk or posedge rst_in) begin
      if (rst_in) chain <= '1;
      else        chain <= {chain[DEPTH-2:0], 1'b0};
   end

   assign rst_int = chain[DEPTH-1];
endmodule

// File: rtl/div_pulse_cond.sv
module div_pulse_cond #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse_in,
   output logic fall_evt
);
   logic [SYNC_LEN-1:0] sync_q;
   logic [FILT_LEN-1:0] win;
   logic                level;
   logic                all_hi, all_lo;

   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("div_pulse_cond: SYNC_LEN must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("div_pulse_cond: FILT_LEN must be at least 2");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_LEN-2:0], pulse_in};
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) win <= '0;
      else     win <= {win[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
   end

   assign all_hi = &win;
   assign all_lo = ~|win;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         level    <= 1'b0;
         fall_evt <= 1'b0;
      end else begin
         if (all_hi)      level <= 1'b1;
         else if (all_lo) level <= 1'b0;
         fall_evt <= level & all_lo;
      end
   end

   // A count event only follows a window of settled low samples
   AST_EVT_AFTER_LOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
      fall_evt |-> $past(all_lo)) else $error("event without settled low"); // R5
   // The filtered level never rises on an event
   AST_EVT_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
      fall_evt |-> !level) else $error("event with level high"); // R2
endmodule

// File: rtl/div_counter.sv
module div_counter #(
   parameter int STAGES = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [STAGES-1:0] cnt,
   output logic              wrap_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("div_counter: STAGES must be at least 2");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt        <= '0;
         wrap_pulse <= 1'b0;
      end else begin
         wrap_pulse <= step & (&cnt);
         if (step) cnt <= cnt + 1'b1;
      end
   end

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
      step |=> cnt == $past(cnt) + 1'b1) else $error("bad increment"); // R1
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(cnt)) else $error("count moved without event"); // R2
   AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      wrap_pulse |-> cnt == '0) else $error("wrap pulse off zero"); // R7
   AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      wrap_pulse |=> !wrap_pulse) else $error("wrap pulse too long"); // R7
endmodule

// File: rtl/ripple_div_top.sv
module ripple_div_top #(
   parameter int STAGES   = 14,
   parameter int FILT_LEN = 3,
   parameter int SYNC_LEN = 2,
   parameter int RST_SYNC = 2,
   localparam int LOW_HIDDEN = 3,
   localparam int MID_HIDDEN = 11,
   localparam int NTAP       = STAGES - LOW_HIDDEN - 1
) (
   input  logic            clk,
   input  logic            rst_in,
   input  logic            pulse_in,
   output logic [NTAP-1:0] tap_q,
   output logic            osc_en,
   output logic            wrap_pulse
);
   import div_pkg::*;

   logic              rst_int;
   logic              fall_evt;
   logic [STAGES-1:0] cnt;

   if (STAGES < MID_HIDDEN + 1) begin : g_bad_top
      $error("ripple_div_top: STAGES must reach past the hidden middle stage");
   end

   div_rst_sync #(.DEPTH(RST_SYNC)) u_rst (
      .clk    (clk),
      .rst_in (rst_in),
      .rst_int(rst_int)
   );

   div_pulse_cond #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_cond (
      .clk     (clk),
      .rst     (rst_int),
      .pulse_in(pulse_in),
      .fall_evt(fall_evt)
   );

   div_counter #(.STAGES(STAGES)) u_cnt (
      .clk       (clk),
      .rst       (rst_int),
      .step      (fall_evt),
      .cnt       (cnt),
      .wrap_pulse(wrap_pulse)
   );

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      assign tap_q[t] = cnt[tap_source(t, LOW_HIDDEN, MID_HIDDEN)];
   end

   assign osc_en = ~rst_int;

   AST_RST_CLEARS: assert property (@(posedge clk)
      rst_in |-> cnt == '0) else $error("count nonzero in reset"); // R3
   AST_OSC_OFF: assert property (@(posedge clk)
      rst_in |-> !osc_en) else $error("oscillator enabled in reset"); // R4
endmodule

// File: tb/tb_ripple_div_top.sv
module tb_ripple_div_top;
   localparam int STAGES = 12;
   localparam int FILT   = 3;
   localparam int NT     = STAGES - 4;

   logic          clk = 1'b0;
   logic          rst_in;
   logic          pulse_in;
   logic [NT-1:0] tap_q;
   logic          osc_en;
   logic          wrap_pulse;

   int tests = 0;
   int fails = 0;
   int model = 0;
   int wraps = 0;
   bit wrap_long = 1'b0;
   logic wrap_prev = 1'b0;

   always #2 clk = ~clk;

   ripple_div_top #(.STAGES(STAGES), .FILT_LEN(FILT)) dut (
      .clk(clk), .rst_in(rst_in), .pulse_in(pulse_in),
      .tap_q(tap_q), .osc_en(osc_en), .wrap_pulse(wrap_pulse)
   );

   always @(negedge clk) begin
      if (wrap_pulse) wraps++;
      if (wrap_pulse && wrap_prev) wrap_long = 1'b1;
      wrap_prev = wrap_pulse;
   end

   // R6: taps are stages 4..10 and 12.. (bits 3..9 and 11..)
   function automatic logic [NT-1:0] exp_taps(input int c);
      logic [NT-1:0] r;
      logic [STAGES-1:0] v;
      v = STAGES'(c);
      for (int i = 0; i < NT; i++) r[i] = (i < 7) ? v[i+3] : v[i+4];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      pulse_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int hi, input int lo);
      hold(1'b1, hi);
      hold(1'b0, lo);
      model = (model + 1) % (1 << STAGES);
   endtask

   task automatic do_reset();
      rst_in = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 osc_en low in reset", 32'(osc_en), 0);
      check("R3 taps zero in reset", 32'(tap_q), 0);
      rst_in = 1'b0;
      repeat (3) @(negedge clk);
      check("R4 osc_en back high", 32'(osc_en), 1);
      model = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int w0;
      void'($urandom(32'h5eed));
      rst_in = 1'b1;
      pulse_in = 1'b0;
      repeat (3) @(negedge clk);
      check("R3 reset state taps", 32'(tap_q), 0);
      check("R4 reset state osc_en", 32'(osc_en), 0);
      check("R7 reset state wrap", 32'(wrap_pulse), 0);
      do_reset();

      // R2: rising edge alone does not count
      hold(1'b1, 12);
      check("R2 rising edge ignored", 32'(tap_q), 32'(exp_taps(0)));
      hold(1'b0, 12);
      model = 1;
      // 8 falls lights stage 4
      for (int i = 0; i < 7; i++) pulse(5, 5);
      hold(1'b0, 10);
      check("R1 eight falls", 32'(tap_q), 32'(exp_taps(model)));
      check("R6 stage 4 tap", 32'(tap_q[0]), 1);

      // R5: short glitches both ways
      hold(1'b1, 1); hold(1'b0, 8);
      hold(1'b1, 2); hold(1'b0, 10);
      check("R5 high glitches ignored", 32'(tap_q), 32'(exp_taps(model)));
      hold(1'b1, 10); hold(1'b0, 2); hold(1'b1, 1); hold(1'b0, 1); hold(1'b1, 10);
      check("R5 low glitches ignored", 32'(tap_q), 32'(exp_taps(model)));
      hold(1'b0, 10);
      model++;
      check("R5 real fall after glitches", 32'(tap_q), 32'(exp_taps(model)));

      // Random bursts with glitches (R1, R5, R6)
      for (int it = 0; it < 25; it++) begin
         int n;
         n = 1 + ($urandom % 40);
         for (int k = 0; k < n; k++) begin
            if ($urandom % 4 == 0) begin
               hold(1'b0, 1 + ($urandom % 2));
               hold(1'b1, 1 + ($urandom % 2));
               hold(1'b0, 4);
            end
            pulse(4 + ($urandom % 4), 4 + ($urandom % 4));
            if ($urandom % 5 == 0) begin
               hold(1'b1, 1 + ($urandom % 2));
               hold(1'b0, 4);
            end
         end
         hold(1'b0, 10);
         check("R1 R6 random burst taps", 32'(tap_q), 32'(exp_taps(model)));
      end

      // R3: reset dominates an arriving fall, and holds zero
      hold(1'b1, 10);
      pulse_in = 1'b0;
      repeat (5) @(negedge clk);
      rst_in = 1'b1;
      repeat (8) @(negedge clk);
      check("R3 reset dominates fall", 32'(tap_q), 0);
      rst_in = 1'b0;
      repeat (12) @(negedge clk);
      check("R3 no late count after reset", 32'(tap_q), 0);
      check("R4 osc_en after release", 32'(osc_en), 1);
      model = 0;

      // R7: full wrap
      for (int i = 0; i < (1 << STAGES) - 1; i++) pulse(4, 4);
      hold(1'b0, 10);
      check("R7 all ones before wrap", 32'(tap_q), 32'(exp_taps((1 << STAGES) - 1)));
      w0 = wraps;
      pulse(4, 4);
      hold(1'b0, 10);
      check("R7 wrapped to zero", 32'(tap_q), 0);
      check("R7 one wrap pulse", 32'(wraps - w0), 1);
      check("R7 wrap pulse single cycle", 32'(wrap_long), 0);
      pulse(4, 4);
      hold(1'b0, 10);
      check("R1 counting resumes after wrap", 32'(tap_q), 32'(exp_taps(model)));
      check("R7 no extra wrap", 32'(wraps - w0), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule